// File: doc/BRIEF.md
# PLL Retune Sequencer

This block changes the divider settings of a PLL through the PLL's own control registers without leaving the clock in an unsafe state. A single start pulse carries the whole new setting: a 12-bit feedback divider, a 6-bit reference divider, two 3-bit post-dividers, a 24-bit fractional divider and the integer-mode bit. The block then acts as the only master on a small register bus and issues a fixed series of accesses. It drops the PLL into slow mode, loads the new dividers, merges the fractional value into its register, selects integer or fractional operation, waits for lock and then puts the PLL back into normal mode.

Every register write carries its own write-enable mask in the upper 16 bits of the data word. The PLL only changes the low-half bits whose mask bit is set. The fractional register has no mask half, so it is updated by a read followed by a write that keeps its top byte. Lock is sampled from bit 31 of that same register. Waiting for lock is bounded: the first poll is issued at once, and each later poll waits for a strobe on `us_tick`, up to `MAX_POLLS` polls in all. If lock never shows, a warning is raised, but the PLL is still returned to normal mode and the run completes.

Top module: `pll_retune_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `lock_warn` and `bus_req` are all low.
- R2: The first access of an accepted request writes 0x0300_0000 to the mode register at BASE+0xC. This sets slow mode (field bits 9:8 = 0) and the mask bits 25:24.
- R3: The second access writes the feedback divider to BASE+0x0 in bits 11:0, with bits 31:16 all set and all other bits clear.
- R4: The third access writes BASE+0x4 with bits 31:16 set, the second post-divider in bits 14:12, the first post-divider in bits 10:8 and the reference divider in bits 5:0. All other bits are clear.
- R5: Next the block reads BASE+0x8. It then writes BASE+0x8 with bits 31:24 equal to the value just read and bits 23:0 equal to the fractional divider.
- R6: The next access writes BASE+0xC with bit 19 set, the integer-mode bit in bit 3 and all other bits clear.
- R7: Lock polls are reads of BASE+0x8. The first follows R6 directly. Each later poll needs at least one `us_tick` strobe after the previous poll's acknowledge. Polling stops at the first read with bit 31 set, and never exceeds `MAX_POLLS` reads.
- R8: If `MAX_POLLS` polls all read bit 31 clear, `lock_warn` rises and the sequence still goes on. `lock_warn` stays high until the next accepted request clears it.
- R9: The last access writes 0x0300_0100 to BASE+0xC (normal mode). After its acknowledge, `done` pulses for one cycle and `busy` falls.
- R10: Once `bus_req` is raised, the request and its address, direction and data stay unchanged until a cycle with `bus_ack`. No later access starts before that acknowledge.
- R11: A start with the feedback, reference, both post- and fractional dividers all zero is rejected. `err` pulses for one cycle, and no bus access and no busy period follow.
- R12: A start that arrives while a sequence is running is ignored. The running sequence keeps the values it latched when it was accepted, and the inputs are free to change after the start cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, sampled only when idle |
| fb_div | input | 12 | Feedback divider |
| ref_div | input | 6 | Reference divider |
| post_div1 | input | 3 | First post-divider |
| post_div2 | input | 3 | Second post-divider |
| frac_div | input | 24 | Fractional divider |
| int_mode | input | 1 | 1 selects integer operation |
| us_tick | input | 1 | One-cycle microsecond strobe pacing lock polls |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | 32 | Write data including mask half |
| bus_ack | input | 1 | One-cycle acknowledge completing the access |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |
| lock_warn | output | 1 | Lock did not arrive within the poll limit |

## Verification
The assertions assume that `bus_ack` is only ever raised while `bus_req` is high, and for exactly one cycle per access. They also assume `us_tick` is a single-cycle strobe. The bench's bus model only acknowledges a pending request, after a random wait of zero to three cycles, and drops the acknowledge on the following cycle. Its tick generator pulses once every fourth cycle. Divider values are drawn at random and are never all zero except in the directed rejection case. The cycle at which lock appears is chosen per run: the first poll, a few polls in, exactly the last allowed poll, or never.

// File: rtl/pll_retune_seq.sv
module pll_retune_seq #(
  parameter int ADDR_W    = 8,
  parameter int BASE      = 0,
  parameter int MAX_POLLS = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [11:0]       fb_div,
  input  logic [5:0]        ref_div,
  input  logic [2:0]        post_div1,
  input  logic [2:0]        post_div2,
  input  logic [23:0]       frac_div,
  input  logic              int_mode,
  input  logic              us_tick,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [31:0]       bus_rdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              lock_warn
);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam logic [ADDR_W-1:0] A_FB   = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(BASE + 4);
  localparam logic [ADDR_W-1:0] A_FRAC = ADDR_W'(BASE + 8);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(BASE + 12);
  localparam int LOCK_BIT = 31;

  typedef enum logic [3:0] {
    S_IDLE, S_SLOW, S_FB, S_DIV, S_FRD, S_FWR, S_IMODE, S_PRD, S_PWAIT, S_NORM
  } st_t;

  st_t         state;
  logic [11:0] fb_q;
  logic [5:0]  ref_q;
  logic [2:0]  p1_q, p2_q;
  logic [23:0] frac_q;
  logic        im_q;
  logic [7:0]  hi_q;
  logic [PW-1:0] poll_cnt;
  logic        done_q, err_q, warn_q;

  wire zero_req = (fb_div == '0) && (ref_div == '0) && (post_div1 == '0) &&
                  (post_div2 == '0) && (frac_div == '0);

  assign busy      = (state != S_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign lock_warn = warn_q;

  always_comb begin
    bus_req   = 1'b1;
    bus_we    = 1'b1;
    bus_addr  = A_MODE;
    bus_wdata = '0;
    case (state)
      S_SLOW:  bus_wdata = 32'h0300_0000;
      S_FB:    begin bus_addr = A_FB;  bus_wdata = {16'hFFFF, 4'h0, fb_q}; end
      S_DIV:   begin
        bus_addr  = A_DIV;
        bus_wdata = {16'hFFFF, 1'b0, p2_q, 1'b0, p1_q, 2'b00, ref_q};
      end
      S_FRD:   begin bus_addr = A_FRAC; bus_we = 1'b0; end
      S_FWR:   begin bus_addr = A_FRAC; bus_wdata = {hi_q, frac_q}; end
      S_IMODE: bus_wdata = {12'h000, 1'b1, 15'h0000, im_q, 3'b000};
      S_PRD:   begin bus_addr = A_FRAC; bus_we = 1'b0; end
      S_NORM:  bus_wdata = 32'h0300_0100;
      default: begin bus_req = 1'b0; bus_we = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      fb_q     <= '0;
      ref_q    <= '0;
      p1_q     <= '0;
      p2_q     <= '0;
      frac_q   <= '0;
      im_q     <= 1'b0;
      hi_q     <= '0;
      poll_cnt <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      warn_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (zero_req) err_q <= 1'b1;
          else begin
            fb_q     <= fb_div;
            ref_q    <= ref_div;
            p1_q     <= post_div1;
            p2_q     <= post_div2;
            frac_q   <= frac_div;
            im_q     <= int_mode;
            warn_q   <= 1'b0;
            poll_cnt <= '0;
            state    <= S_SLOW;
          end
        end
        S_SLOW:  if (bus_ack) state <= S_FB;
        S_FB:    if (bus_ack) state <= S_DIV;
        S_DIV:   if (bus_ack) state <= S_FRD;
        S_FRD:   if (bus_ack) begin hi_q <= bus_rdata[31:24]; state <= S_FWR; end
        S_FWR:   if (bus_ack) state <= S_IMODE;
        S_IMODE: if (bus_ack) state <= S_PRD;
        S_PRD:   if (bus_ack) begin
          if (bus_rdata[LOCK_BIT]) state <= S_NORM;
          else if (poll_cnt == PW'(MAX_POLLS - 1)) begin
            warn_q <= 1'b1;
            state  <= S_NORM;
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
            state    <= S_PWAIT;
          end
        end
        S_PWAIT: if (us_tick) state <= S_PRD;
        S_NORM:  if (bus_ack) begin done_q <= 1'b1; state <= S_IDLE; end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  // R2
  slow_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (bus_req && bus_we && bus_addr == A_MODE && bus_wdata == 32'h0300_0000));

  // R11
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !bus_req && !done));

  // R8
  warn_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_warn) |-> (state == S_NORM));

  // R7
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (poll_cnt < PW'(MAX_POLLS)));

  // R7
  tick_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PWAIT && !us_tick) |=> (state == S_PWAIT && !bus_req));

  // R9
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

// File: tb/pll_retune_seq_tb.sv
module pll_retune_seq_tb;
  localparam int MAXP = 1000;
  localparam logic [7:0] A0 = 8'h00, A1 = 8'h04, A2 = 8'h08, A3 = 8'h0C;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, int_mode = 1'b0, us_tick = 1'b0;
  logic [11:0] fb_div = '0;
  logic [5:0]  ref_div = '0;
  logic [2:0]  post_div1 = '0, post_div2 = '0;
  logic [23:0] frac_div = '0;
  logic bus_req, bus_we, bus_ack = 1'b0;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata = '0;
  logic busy, done, err, lock_warn;

  int checks = 0, errors = 0;
  int step = 0, polls = 0, lock_at = 0, lat = 0;
  int ticks_total = 0, tick_mark = 0, tcnt = 0;
  logic [11:0] e_fb; logic [5:0] e_ref; logic [2:0] e_p1, e_p2;
  logic [23:0] e_frac; logic e_im; logic [31:0] seed_word;

  always #5 clk = ~clk;

  pll_retune_seq #(.ADDR_W(8), .BASE(0), .MAX_POLLS(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fb_div(fb_div), .ref_div(ref_div),
    .post_div1(post_div1), .post_div2(post_div2), .frac_div(frac_div),
    .int_mode(int_mode), .us_tick(us_tick), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .busy(busy), .done(done), .err(err), .lock_warn(lock_warn));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_div();
    return {16'hFFFF, 1'b0, e_p2, 1'b0, e_p1, 2'b00, e_ref};
  endfunction

  function automatic int exp_polls();
    return (lock_at >= 1 && lock_at <= MAXP) ? lock_at : MAXP;
  endfunction

  always @(negedge clk) begin
    us_tick <= 1'b0;
    if (rst_n) begin
      tcnt = (tcnt + 1) % 4;
      if (tcnt == 0) begin us_tick <= 1'b1; ticks_total++; end
    end
  end

  always @(negedge clk) begin
    if (bus_ack) bus_ack = 1'b0;
    else if (bus_req && rst_n) begin
      if (lat > 0) lat--;
      else begin
        lat = $urandom_range(0, 3);
        bus_rdata = $urandom;
        case (step)
          0: check(bus_we && bus_addr == A3 && bus_wdata == 32'h0300_0000, "R2 slow write", bus_wdata, 32'h0300_0000);
          1: check(bus_we && bus_addr == A0 && bus_wdata == {16'hFFFF, 4'h0, e_fb}, "R3 fb write", bus_wdata, {16'hFFFF, 4'h0, e_fb});
          2: check(bus_we && bus_addr == A1 && bus_wdata == exp_div(), "R4 div write", bus_wdata, exp_div());
          3: begin
            check(!bus_we && bus_addr == A2, "R5 frac read", {bus_we, bus_addr}, {1'b0, A2});
            seed_word = $urandom;
            bus_rdata = seed_word;
          end
          4: check(bus_we && bus_addr == A2 && bus_wdata == {seed_word[31:24], e_frac}, "R5 frac write", bus_wdata, {seed_word[31:24], e_frac});
          5: check(bus_we && bus_addr == A3 && bus_wdata == {12'h0, 1'b1, 15'h0, e_im, 3'b0}, "R6 mode bit write", bus_wdata, {12'h0, 1'b1, 15'h0, e_im, 3'b0});
          default: begin
            if (!bus_we && bus_addr == A2) begin
              polls++;
              if (polls > 1) check(ticks_total > tick_mark, "R7 tick between polls", ticks_total, tick_mark + 1);
              if (polls > MAXP) check(1'b0, "R7 poll limit", polls, MAXP);
              tick_mark = ticks_total;
              bus_rdata[31] = (polls == lock_at);
            end else begin
              check(bus_we && bus_addr == A3 && bus_wdata == 32'h0300_0100, "R9 normal write", bus_wdata, 32'h0300_0100);
              check(polls == exp_polls(), "R7 poll count", polls, exp_polls());
            end
          end
        endcase
        step++;
        bus_ack = 1'b1;
      end
    end
  end

  task automatic drive_start(input logic [11:0] f, input logic [5:0] r, input logic [2:0] a,
                             input logic [2:0] b, input logic [23:0] fr, input logic m);
    fb_div = f; ref_div = r; post_div1 = a; post_div2 = b; frac_div = fr; int_mode = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fb_div = $urandom; ref_div = $urandom; post_div1 = $urandom;
    post_div2 = $urandom; frac_div = $urandom; int_mode = $urandom;
  endtask

  task automatic run(input int lk, input bit poke);
    bit seen;
    e_fb = $urandom_range(1, 4095); e_ref = $urandom; e_p1 = $urandom; e_p2 = $urandom;
    e_frac = $urandom; e_im = $urandom;
    lock_at = lk; step = 0; polls = 0;
    drive_start(e_fb, e_ref, e_p1, e_p2, e_frac, e_im);
    check(busy == 1'b1 && lock_warn == 1'b0, "R8 busy and warn cleared at accept", {busy, lock_warn}, 2'b10);
    if (poke) begin
      repeat (3) @(negedge clk);
      drive_start(~e_fb, ~e_ref, ~e_p1, ~e_p2, ~e_frac, ~e_im);
    end
    seen = 1'b0;
    for (int i = 0; i < 20000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    check(seen, poke ? "R12 run completes after ignored start" : "R9 done pulse", seen, 1);
    check(!busy, "R9 busy low at done", busy, 0);
    check(lock_warn == (exp_polls() == MAXP && lock_at != MAXP), "R8 lock warning", lock_warn, exp_polls() == MAXP && lock_at != MAXP);
    check(step == 7 + exp_polls(), "R10 access count", step, 7 + exp_polls());
    @(negedge clk);
    check(!done && !busy, "R9 done one cycle", {done, busy}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, err, lock_warn, bus_req} == 5'b0, "R1 reset state", {busy, done, err, lock_warn, bus_req}, 0);

    drive_start('0, '0, '0, '0, '0, 1'b1);
    check(err && !busy && !bus_req, "R11 zero request rejected", {err, busy, bus_req}, 3'b100);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(!bus_req && !busy && !err, "R11 no traffic after reject", {bus_req, busy, err}, 0);
    end

    run(1, 1'b0);
    run(0, 1'b0);
    run(3, 1'b0);
    run(MAXP, 1'b0);
    run(2, 1'b1);
    for (int k = 0; k < 8; k++) run($urandom_range(1, 6), k[0]);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule